// File: doc/BRIEF.md
# Runtime-Selectable Bit-Serial CRC Engine

This block divides a serial bit stream by a generator polynomial in modulo-2 arithmetic, one bit per accepted cycle, in a shift register whose feedback XOR taps depend on the chosen polynomial. Three generators share the datapath: a 12-bit one and two 16-bit ones. The caller picks one when a frame opens, then feeds bits most significant first under a valid strobe.

On the sending side the remainder on the parallel output is the frame check sequence, and the caller appends it after the message. On the receiving side the caller shifts in the message followed by its check sequence and marks the last one with an end-of-frame pulse. One cycle later the block reports whether the register came to all zeros.

The feedback form folds the n appended zero bits into the division. The remainder is therefore ready in the cycle after the last message bit, with no flush cycles.

Top module: `crc_serial_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, rem_o is 0, pass_vld_o is 0 and pass_o is 0.
- R2: A cycle with sof_i high clears the register, so rem_o is 0 in the following cycle. A bit offered with bit_vld_i in that same cycle is not taken into the division.
- R3: poly_sel_i codes: 0 selects x^12+x^11+x^3+x^2+x+1 (12-bit remainder), 1 selects x^16+x^15+x^2+1, 2 selects x^16+x^12+x^5+1, and 3 acts exactly like 2.
- R4: Each cycle with bit_vld_i high and sof_i low shifts bit_i in, most significant message bit first. In the following cycle rem_o holds M(x)·x^n mod P(x) over all bits taken since the last sof_i, right-aligned. For the 12-bit generator, rem_o[15:12] is 0.
- R5: A cycle with bit_vld_i low and sof_i low leaves rem_o unchanged, whatever bit_i is.
- R6: poly_sel_i is sampled only in a cycle with sof_i high. Changing it at any other time has no effect on the running division.
- R7: If a message is followed by its own remainder, sent most significant bit first, the register ends at all zeros. If any bit of that stream is flipped, it does not.
- R8: pass_vld_o is high for exactly the one cycle after a cycle with eof_i high. In that cycle pass_o is 1 only if the register, including any bit taken in the eof_i cycle, is all zeros. pass_o is 0 whenever pass_vld_o is 0.
- R9: eof_i given in a cycle with bit_vld_i low judges the register as it stands, with no bit added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start of frame: clears the register and latches the polynomial select |
| poly_sel_i | input | 2 | Generator select, sampled at sof_i |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| bit_i | input | 1 | Serial data bit |
| eof_i | input | 1 | Last bit of the frame (or an idle judge cycle) |
| rem_o | output | 16 | Current remainder, right-aligned |
| pass_vld_o | output | 1 | Check result valid |
| pass_o | output | 1 | Register was all zeros at end of frame |

## Verification
A wrong tap, mask or feedback bit corrupts the remainder from the first bit that hits it, and that error stays in the register. It shows on rem_o in the cycle after the last message bit, and pass_o drops in a self-checking frame. The bench compares against published check values for the nine-byte ASCII string "123456789", one per generator. A select latched at the wrong time, or a register not cleared, shows the same way: the final remainder differs from the value for the latched polynomial. A fault in the pass logic shows within one cycle of eof_i, as a missing pulse, a second pulse, or a flag that disagrees with rem_o.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W_MAX = 16;
  localparam int unsigned CRC_DEG_SHORT = 12;

  typedef enum logic [1:0] {
    POLY_CRC12 = 2'd0,
    POLY_CRC16 = 2'd1,
    POLY_CCITT = 2'd2,
    POLY_ALIAS = 2'd3
  } poly_e;

  typedef struct packed {
    logic [CRC_W_MAX-1:0] taps;  // generator without its x^n term
    logic [CRC_W_MAX-1:0] mask;  // live register bits
    logic [CRC_W_MAX-1:0] top;   // MSB position
  } poly_cfg_t;

  function automatic poly_cfg_t make_cfg(input logic [CRC_W_MAX-1:0] taps,
                                         input int unsigned deg);
    poly_cfg_t c;
    c.taps = taps;
    c.mask = {CRC_W_MAX{1'b1}} >> (CRC_W_MAX - deg);
    c.top  = {{(CRC_W_MAX-1){1'b0}}, 1'b1} << (deg - 1);
    return c;
  endfunction
endpackage

// File: rtl/crc_poly_table.sv
module crc_poly_table
  import crc_pkg::*;
(
  input  poly_e     sel_i,
  output poly_cfg_t cfg_o
);
  always_comb begin
    unique case (sel_i)
      POLY_CRC12: cfg_o = make_cfg(16'h080F, CRC_DEG_SHORT);
      POLY_CRC16: cfg_o = make_cfg(16'h8005, CRC_W_MAX);
      default:    cfg_o = make_cfg(16'h1021, CRC_W_MAX);
    endcase
  end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg
  import crc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  input  poly_cfg_t            cfg_i,
  output logic [CRC_W_MAX-1:0] crc_o,
  output logic [CRC_W_MAX-1:0] nxt_o
);
  logic [CRC_W_MAX-1:0] crc_q, crc_d, shifted;
  logic                 fb;

  always_comb begin
    fb      = (|(crc_q & cfg_i.top)) ^ bit_i;
    shifted = ((crc_q << 1) ^ (fb ? cfg_i.taps : '0)) & cfg_i.mask;
    if (clr_i)        crc_d = '0;
    else if (shift_i) crc_d = shifted;
    else              crc_d = crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;

  assign crc_o = crc_q;
  assign nxt_o = crc_d;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_sel_ctl.sv
module crc_sel_ctl
  import crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sof_i,
  input  poly_e sel_i,
  input  logic  eof_i,
  input  logic  nxt_zero_i,
  output poly_e sel_o,
  output logic  pass_vld_o,
  output logic  pass_o
);
  poly_e sel_q;
  logic  vld_q, pass_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sel_q  <= POLY_CRC12;
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (sof_i) sel_q <= sel_i;
      vld_q  <= eof_i;
      pass_q <= eof_i & nxt_zero_i;
    end

  assign sel_o      = sel_q;
  assign pass_vld_o = vld_q;
  assign pass_o     = pass_q;

  p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(sel_q));
  p_pulse_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> $past(eof_i));
  p_pass_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> !pass_q);
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic [1:0]           poly_sel_i,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic                 eof_i,
  output logic [CRC_W_MAX-1:0] rem_o,
  output logic                 pass_vld_o,
  output logic                 pass_o
);
  poly_e                sel_q;
  poly_cfg_t            cfg;
  logic [CRC_W_MAX-1:0] nxt;

  crc_sel_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .sel_i      (poly_e'(poly_sel_i)),
    .eof_i      (eof_i),
    .nxt_zero_i (nxt == '0),
    .sel_o      (sel_q),
    .pass_vld_o (pass_vld_o),
    .pass_o     (pass_o)
  );

  crc_poly_table u_tab (
    .sel_i (sel_q),
    .cfg_o (cfg)
  );

  // sof clears in the same edge that loads the new select
  crc_shift_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sof_i),
    .shift_i (bit_vld_i),
    .bit_i   (bit_i),
    .cfg_i   (cfg),
    .crc_o   (rem_o),
    .nxt_o   (nxt)
  );

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (rem_o == '0));
  p_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == POLY_CRC12) |-> (rem_o[CRC_W_MAX-1:CRC_DEG_SHORT] == '0));
  p_pass_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_vld_o |-> (pass_o == (rem_o == '0)));
endmodule

// File: tb/sim_crc_serial_unit.sv
module sim_crc_serial_unit;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sof_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, eof_i = 1'b0;
  logic [1:0] poly_sel_i = 2'd0;
  logic [15:0] rem_o;
  logic pass_vld_o, pass_o;
  int total = 0, bad = 0, cycles = 0;

  localparam logic [71:0] MSG = 72'h313233343536373839;  // "123456789"
  localparam logic [15:0] CHK12 = 16'h0F5B, CHK16 = 16'hFEE8, CHKCC = 16'h31C3;

  always #10 clk_i = ~clk_i;

  crc_serial_unit u0 (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] sel, input logic with_bit);
    sof_i = 1'b1; poly_sel_i = sel; bit_vld_i = with_bit; bit_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0; bit_vld_i = 1'b0;
  endtask

  task automatic put(input logic b, input logic last);
    bit_i = b; bit_vld_i = 1'b1; eof_i = last;
    @(negedge clk_i);
    bit_vld_i = 1'b0; eof_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bit_i = ~bit_i;
      @(negedge clk_i);
    end
  endtask

  task automatic send_msg(input int gap, input int flip, input logic [1:0] mid_sel);
    for (int i = 0; i < 72; i++) begin
      poly_sel_i = mid_sel;
      put(MSG[71-i] ^ (i == flip), 1'b0);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic send_fcs(input logic [15:0] f, input int w, input logic eof_last);
    for (int i = w - 1; i >= 0; i--) put(f[i], eof_last && (i == 0));
  endtask

  task automatic t_reset;
    chk(rem_o == 0, "R1 rem", rem_o, 0);
    chk(pass_vld_o == 0 && pass_o == 0, "R1 pass", {pass_vld_o, pass_o}, 0);
  endtask

  task automatic t_gen(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    start(sel, 1'b0);
    chk(rem_o == 0, "R2 cleared", rem_o, 0);
    send_msg(0, -1, sel);
    chk(rem_o == exp, tag, rem_o, exp);
  endtask

  task automatic t_check(input logic [1:0] sel, input logic [15:0] fcs, input int w);
    start(sel, 1'b0);
    send_msg(0, -1, sel);
    send_fcs(fcs, w, 1'b1);
    chk(pass_vld_o && pass_o, "R7 pass good frame", {pass_vld_o, pass_o}, 3);
    chk(rem_o == 0, "R7 zero rem", rem_o, 0);
    idle(1);
    chk(!pass_vld_o && !pass_o, "R8 one-cycle pulse", {pass_vld_o, pass_o}, 0);
  endtask

  task automatic t_corrupt;
    start(2'd1, 1'b0);
    send_msg(0, 37, 2'd1);
    send_fcs(CHK16, 16, 1'b1);
    chk(pass_vld_o && !pass_o, "R7 flipped bit fails", {pass_vld_o, pass_o}, 2);
  endtask

  task automatic t_gaps;
    start(2'd2, 1'b0);
    send_msg(2, -1, 2'd2);
    chk(rem_o == CHKCC, "R5 gaps ignored", rem_o, CHKCC);
  endtask

  task automatic t_mid_sel;
    start(2'd2, 1'b0);
    send_msg(0, -1, 2'd0);
    chk(rem_o == CHKCC, "R6 select latched", rem_o, CHKCC);
  endtask

  task automatic t_restart;
    start(2'd0, 1'b0);
    for (int i = 0; i < 5; i++) put(1'b1, 1'b0);
    start(2'd0, 1'b1);
    chk(rem_o == 0, "R2 bit with sof dropped", rem_o, 0);
    send_msg(0, -1, 2'd0);
    chk(rem_o == CHK12, "R2 restart", rem_o, CHK12);
  endtask

  task automatic t_idle_eof;
    start(2'd0, 1'b0);
    send_msg(0, -1, 2'd0);
    send_fcs(CHK12, 12, 1'b0);
    eof_i = 1'b1;
    @(negedge clk_i);
    eof_i = 1'b0;
    chk(pass_vld_o && pass_o, "R9 idle eof", {pass_vld_o, pass_o}, 3);
    start(2'd0, 1'b0);
    send_msg(0, -1, 2'd0);
    eof_i = 1'b1;
    @(negedge clk_i);
    eof_i = 1'b0;
    chk(pass_vld_o && !pass_o, "R9 nonzero judged", {pass_vld_o, pass_o}, 2);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_gen(2'd0, CHK12, "R3 R4 crc12");
    chk(rem_o[15:12] == 0, "R4 narrow upper zero", rem_o, CHK12);
    t_gen(2'd1, CHK16, "R3 R4 crc16");
    t_gen(2'd2, CHKCC, "R3 R4 ccitt");
    t_gen(2'd3, CHKCC, "R3 alias code");
    t_check(2'd0, CHK12, 12);
    t_check(2'd2, CHKCC, 16);
    t_corrupt;
    t_gaps;
    t_mid_sel;
    t_restart;
    t_idle_eof;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule